// File: doc/BRIEF.md
# Three-Level Page Table Walker

The walker turns a 32-bit logical address into a physical address by reading descriptors from a table tree with a fixed layout. It accepts one request at a time, with a function code, a read/write flag, a test-mode flag and a page-size select (4 KB or 8 KB pages). Before it starts a walk, it compares the request with two transparent windows. A matching window passes the address through unchanged, and no memory is read.

When no window matches, the walker reads three descriptors in order through a single-outstanding memory port: a root entry, a pointer entry and a page descriptor. The root pointer is taken from the supervisor register when function-code bit 2 is set and from the user register otherwise. A page descriptor may point to one further descriptor, and the walker follows that single indirection. Invalid entries and writes to protected regions end the walk with a bus error. In test mode these faults are suppressed, and the walk reports where it stopped.

Top module: `mmu_walker`

## Requirements
- R1: A window register matches when its bit 15 is set, when logical address bits 31:24 equal window bits 31:24 in every position where window bits 23:16 hold 0, and when the function code is accepted by the selector in window bits 14:13 (0 = only fc[2]=0, 1 = only fc[2]=1, 2 or 3 = any). A match raises `done` one cycle after acceptance with `phys_addr` equal to the logical address, and no memory request is made.
- R2: A write that hits a window whose bit 2 is set ends with `bus_err` high, unless test mode is on.
- R3: A walk starts by reading the root entry at (root pointer with its low 9 bits cleared) + address[31:25]*4. The root pointer is `root_super` when fc[2]=1 and `root_user` otherwise. A root entry with bit 1 clear is invalid.
- R4: The pointer entry is read at (root entry with its low 9 bits cleared) + address[24:18]*4. A pointer entry with bit 1 clear is invalid and ends the walk with a bus error.
- R5: With `req_big_page`=0, the page descriptor is read at (pointer entry with its low 8 bits cleared) + address[17:12]*4. The result is descriptor bits 31:12 joined with address bits 11:0.
- R6: With `req_big_page`=1, the page descriptor is read at (pointer entry with its low 7 bits cleared) + address[17:13]*4. The result is descriptor bits 31:13 joined with address bits 12:0.
- R7: A page descriptor whose bits 1:0 equal 2 is indirect. The walker reads again at the descriptor value with bits 1:0 cleared. Types 1 and 3 are resident and complete the translation.
- R8: An indirect descriptor reached through an indirect descriptor ends the walk with `bus_err` high, in test mode as well. `phys_addr` is the address of that second descriptor.
- R9: A page descriptor of type 0 (bits 1:0 = 0), whether reached directly or through an indirection, ends the walk with a bus error.
- R10: A write whose root entry or pointer entry has bit 2 set ends with a bus error once the pointer entry has been read. Reads through the same entries translate normally.
- R11: In test mode, write protection is ignored, and an invalid root, pointer or page entry ends the walk with `bus_err` low. In that case `phys_addr` is the address of the invalid descriptor. Without test mode, a faulting walk also reports the address of the faulting descriptor.
- R12: After reset, `req_ready` is high and `mem_req`, `done` and `bus_err` are low. `mem_addr` holds steady while `mem_req` waits for `mem_ack`. `req_ready` is low during a walk. `done` is a one-cycle pulse, and `bus_err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle; a request is accepted at this edge |
| req_addr | input | 32 | Logical address |
| req_fc | input | 3 | Function code |
| req_write | input | 1 | Access is a write |
| req_test | input | 1 | Test mode: suppress faults and report the stop point |
| req_big_page | input | 1 | 1 = 8 KB pages, 0 = 4 KB pages |
| root_user | input | 32 | Root table pointer for fc[2]=0 |
| root_super | input | 32 | Root table pointer for fc[2]=1 |
| tt_win0 | input | 32 | Transparent window 0 |
| tt_win1 | input | 32 | Transparent window 1 |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | Translation complete (one cycle) |
| phys_addr | output | 32 | Physical address, or faulting descriptor address |
| bus_err | output | 1 | Translation ended in a bus error |

## Verification
The bench builds the walker with its default geometry: 7 root-index bits, 7 pointer-index bits and a 12-bit small page offset. This leaves a 6-bit page index for 4 KB pages and a 5-bit index for 8 KB pages, so both page sizes, their different pointer-entry clearing and offset widths, can be checked on one build. The bench's memory responds after 0, 1 or 2 wait cycles, which exercises requests that are held across stall cycles as well as back-to-back descriptor reads.

// File: rtl/mmu_walk_pkg.sv
package mmu_walk_pkg;

    localparam int unsigned ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    // Descriptor and window bit positions used by the walk.
    localparam int unsigned DESC_VALID_BIT = 1;
    localparam int unsigned DESC_WP_BIT    = 2;
    localparam int unsigned WIN_EN_BIT     = 15;
    localparam int unsigned WIN_WP_BIT     = 2;

    localparam logic [1:0] PG_INVALID  = 2'd0;
    localparam logic [1:0] PG_INDIRECT = 2'd2;

    typedef enum logic [2:0] {
        WS_IDLE = 3'd0,
        WS_ROOT = 3'd1,
        WS_PTR  = 3'd2,
        WS_PAGE = 3'd3,
        WS_IND  = 3'd4
    } walk_st_e;

    typedef struct packed {
        walk_st_e st;
        addr_t    va;
        logic     wr;
        logic     tst;
        logic     big;
        logic     wp;
        addr_t    cur;
        logic     done;
        addr_t    pa;
        logic     err;
    } walk_reg_t;

    function automatic addr_t align_down(addr_t v, int unsigned b);
        return (v >> b) << b;
    endfunction

    function automatic addr_t field(addr_t v, int unsigned lsb, int unsigned w);
        return (v >> lsb) & ((addr_t'(1) << w) - addr_t'(1));
    endfunction

endpackage

// File: rtl/mmu_tt_match.sv
module mmu_tt_match
    import mmu_walk_pkg::*;
(
    input  addr_t      win,
    input  addr_t      va,
    input  logic [2:0] fc,
    output logic       hit,
    output logic       wp
);
    logic [7:0] base;
    logic [7:0] ignore;
    logic [1:0] sel;
    logic       fc_ok;
    logic       addr_ok;
    logic       unused_bits;

    assign base   = win[31:24];
    assign ignore = win[23:16];
    assign sel    = win[14:13];

    always_comb begin
        unique case (sel)
            2'd0:    fc_ok = ~fc[2];
            2'd1:    fc_ok = fc[2];
            default: fc_ok = 1'b1;
        endcase
    end

    assign addr_ok     = ((va[31:24] ^ base) & ~ignore) == 8'h00;
    assign hit         = win[WIN_EN_BIT] & fc_ok & addr_ok;
    assign wp          = win[WIN_WP_BIT];
    assign unused_bits = ^{win[12:3], win[1:0], va[23:0], fc[1:0]};

endmodule

// File: rtl/mmu_desc_addr.sv
module mmu_desc_addr
    import mmu_walk_pkg::*;
#(
    parameter int unsigned ROOT_BITS   = 7,
    parameter int unsigned PTR_BITS    = 7,
    parameter int unsigned SMALL_SHIFT = 12
) (
    input  addr_t root_ptr,
    input  addr_t req_va,
    input  addr_t va,
    input  addr_t desc,
    input  logic  big,
    output addr_t root_at,
    output addr_t ptr_at,
    output addr_t page_at,
    output addr_t ind_at,
    output addr_t phys
);
    localparam int unsigned PG_TOP    = ADDR_W - ROOT_BITS - PTR_BITS;
    localparam int unsigned SMALL_IDX = PG_TOP - SMALL_SHIFT;
    localparam int unsigned BIG_SHIFT = SMALL_SHIFT + 1;
    localparam int unsigned BIG_IDX   = SMALL_IDX - 1;

    assign root_at = align_down(root_ptr, ROOT_BITS + 2)
                   + (field(req_va, ADDR_W - ROOT_BITS, ROOT_BITS) << 2);
    assign ptr_at  = align_down(desc, PTR_BITS + 2)
                   + (field(va, PG_TOP, PTR_BITS) << 2);
    assign page_at = big
                   ? align_down(desc, BIG_IDX + 2) + (field(va, BIG_SHIFT, BIG_IDX) << 2)
                   : align_down(desc, SMALL_IDX + 2) + (field(va, SMALL_SHIFT, SMALL_IDX) << 2);
    assign ind_at  = align_down(desc, 2);
    assign phys    = big
                   ? align_down(desc, BIG_SHIFT) | field(va, 0, BIG_SHIFT)
                   : align_down(desc, SMALL_SHIFT) | field(va, 0, SMALL_SHIFT);

endmodule

// File: rtl/mmu_walker.sv
module mmu_walker
    import mmu_walk_pkg::*;
#(
    parameter int unsigned ROOT_BITS   = 7,
    parameter int unsigned PTR_BITS    = 7,
    parameter int unsigned SMALL_SHIFT = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic [2:0]  req_fc,
    input  logic        req_write,
    input  logic        req_test,
    input  logic        req_big_page,
    input  logic [31:0] root_user,
    input  logic [31:0] root_super,
    input  logic [31:0] tt_win0,
    input  logic [31:0] tt_win1,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic [31:0] phys_addr,
    output logic        bus_err
);
    localparam int unsigned NUM_WIN = 2;

    walk_reg_t q, d;

    addr_t               win [NUM_WIN];
    logic [NUM_WIN-1:0]  w_hit;
    logic [NUM_WIN-1:0]  w_wp;
    logic                tt_hit;
    logic                tt_wp;
    addr_t               root_sel;
    addr_t               root_at, ptr_at, page_at, ind_at, phys;

    assign win[0] = tt_win0;
    assign win[1] = tt_win1;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        mmu_tt_match i_match (
            .win (win[g]),
            .va  (req_addr),
            .fc  (req_fc),
            .hit (w_hit[g]),
            .wp  (w_wp[g])
        );
    end

    assign tt_hit   = |w_hit;
    assign tt_wp    = |(w_hit & w_wp);
    assign root_sel = req_fc[2] ? root_super : root_user;

    mmu_desc_addr #(
        .ROOT_BITS   (ROOT_BITS),
        .PTR_BITS    (PTR_BITS),
        .SMALL_SHIFT (SMALL_SHIFT)
    ) i_addr (
        .root_ptr (root_sel),
        .req_va   (req_addr),
        .va       (q.va),
        .desc     (mem_rdata),
        .big      (q.big),
        .root_at  (root_at),
        .ptr_at   (ptr_at),
        .page_at  (page_at),
        .ind_at   (ind_at),
        .phys     (phys)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.st)
            WS_IDLE: begin
                if (req_valid) begin
                    d.va  = req_addr;
                    d.wr  = req_write;
                    d.tst = req_test;
                    d.big = req_big_page;
                    d.wp  = 1'b0;
                    if (tt_hit) begin
                        d.done = 1'b1;
                        d.pa   = req_addr;
                        d.err  = req_write & tt_wp & ~req_test;
                    end else begin
                        d.st  = WS_ROOT;
                        d.cur = root_at;
                    end
                end
            end
            WS_ROOT: begin
                if (mem_ack) begin
                    if (!mem_rdata[DESC_VALID_BIT]) begin
                        d.st   = WS_IDLE;
                        d.done = 1'b1;
                        d.pa   = q.cur;
                        d.err  = ~q.tst;
                    end else begin
                        d.wp  = mem_rdata[DESC_WP_BIT];
                        d.st  = WS_PTR;
                        d.cur = ptr_at;
                    end
                end
            end
            WS_PTR: begin
                if (mem_ack) begin
                    if (!mem_rdata[DESC_VALID_BIT]) begin
                        d.st   = WS_IDLE;
                        d.done = 1'b1;
                        d.pa   = q.cur;
                        d.err  = ~q.tst;
                    end else if (q.wr && (q.wp || mem_rdata[DESC_WP_BIT]) && !q.tst) begin
                        d.st   = WS_IDLE;
                        d.done = 1'b1;
                        d.pa   = q.cur;
                        d.err  = 1'b1;
                    end else begin
                        d.st  = WS_PAGE;
                        d.cur = page_at;
                    end
                end
            end
            WS_PAGE, WS_IND: begin
                if (mem_ack) begin
                    if (mem_rdata[1:0] == PG_INVALID) begin
                        d.st   = WS_IDLE;
                        d.done = 1'b1;
                        d.pa   = q.cur;
                        d.err  = ~q.tst;
                    end else if (mem_rdata[1:0] == PG_INDIRECT) begin
                        if (q.st == WS_PAGE) begin
                            d.st  = WS_IND;
                            d.cur = ind_at;
                        end else begin
                            d.st   = WS_IDLE;
                            d.done = 1'b1;
                            d.pa   = q.cur;
                            d.err  = 1'b1;
                        end
                    end else begin
                        d.st   = WS_IDLE;
                        d.done = 1'b1;
                        d.pa   = phys;
                    end
                end
            end
            default: d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == WS_IDLE);
    assign mem_req   = (q.st != WS_IDLE);
    assign mem_addr  = q.cur;
    assign done      = q.done;
    assign phys_addr = q.pa;
    assign bus_err   = q.err;

endmodule

// File: rtl/mmu_walk_chk.sv
module mmu_walk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        done,
    input logic        bus_err
);
    assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    assert_err_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> done);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_word_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_walk_from_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(req_valid && req_ready));

endmodule

bind mmu_walker mmu_walk_chk i_mmu_walk_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .done      (done),
    .bus_err   (bus_err)
);

// File: tb/test_mmu_walker.sv
module test_mmu_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_fc = '0;
    logic        req_write = 1'b0;
    logic        req_test = 1'b0;
    logic        req_big_page = 1'b0;
    logic [31:0] root_user = 32'h0001_0000;
    logic [31:0] root_super = 32'h0002_0000;
    logic [31:0] tt_win0 = '0;
    logic [31:0] tt_win1 = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] phys_addr;
    logic        bus_err;

    always #10 clk = ~clk;

    mmu_walker i_mmu_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_fc       (req_fc),
        .req_write    (req_write),
        .req_test     (req_test),
        .req_big_page (req_big_page),
        .root_user    (root_user),
        .root_super   (root_super),
        .tt_win0      (tt_win0),
        .tt_win1      (tt_win1),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .done         (done),
        .phys_addr    (phys_addr),
        .bus_err      (bus_err)
    );

    int          n_chk = 0;
    int          n_err = 0;
    int          lat = 0;
    int          wait_cnt = 0;
    bit          pending = 1'b0;
    string       cur_tag = "";
    logic [31:0] exp_pa;
    logic        exp_err;
    logic [31:0] exp_q[$];
    logic [31:0] mem [logic [31:0]];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic bit win_hit(input logic [31:0] t, input logic [31:0] va, input logic [2:0] fc);
        bit fc_ok;
        if (!t[15]) return 1'b0;
        if (t[14:13] == 2'd0) fc_ok = (fc[2] == 1'b0);
        else if (t[14:13] == 2'd1) fc_ok = (fc[2] == 1'b1);
        else fc_ok = 1'b1;
        return fc_ok && (((va[31:24] ^ t[31:24]) & ~t[23:16]) == 8'h00);
    endfunction

    // Reference model: computes the expected descriptor reads and outcome.
    task automatic predict(input logic [31:0] va, input logic [2:0] fc, input bit wr, input bit tst, input bit big);
        logic [31:0] ra, re, pa, pe, ga, ge, ia, ie, fin;
        bit h0, h1, wpw;
        exp_q.delete();
        h0 = win_hit(tt_win0, va, fc);
        h1 = win_hit(tt_win1, va, fc);
        if (h0 || h1) begin
            wpw = (h0 && tt_win0[2]) || (h1 && tt_win1[2]);
            exp_pa = va;
            exp_err = wr && wpw && !tst;
            return;
        end
        ra = ((fc[2] ? root_super : root_user) & ~32'h1FF) + ((va >> 25) & 32'h7F) * 4;
        exp_q.push_back(ra);
        re = rd(ra);
        if (!re[1]) begin exp_pa = ra; exp_err = !tst; return; end
        pa = (re & ~32'h1FF) + ((va >> 18) & 32'h7F) * 4;
        exp_q.push_back(pa);
        pe = rd(pa);
        if (!pe[1]) begin exp_pa = pa; exp_err = !tst; return; end
        if (wr && (re[2] || pe[2]) && !tst) begin exp_pa = pa; exp_err = 1'b1; return; end
        if (big) ga = (pe & ~32'h7F) + ((va >> 13) & 32'h1F) * 4;
        else     ga = (pe & ~32'hFF) + ((va >> 12) & 32'h3F) * 4;
        exp_q.push_back(ga);
        ge = rd(ga);
        fin = ge;
        if (ge[1:0] == 2'd0) begin exp_pa = ga; exp_err = !tst; return; end
        if (ge[1:0] == 2'd2) begin
            ia = ge & ~32'h3;
            exp_q.push_back(ia);
            ie = rd(ia);
            if (ie[1:0] == 2'd2) begin exp_pa = ia; exp_err = 1'b1; return; end
            if (ie[1:0] == 2'd0) begin exp_pa = ia; exp_err = !tst; return; end
            fin = ie;
        end
        exp_pa = big ? ((fin & ~32'h1FFF) | (va & 32'h1FFF)) : ((fin & ~32'hFFF) | (va & 32'hFFF));
        exp_err = 1'b0;
    endtask

    task automatic build(input logic [31:0] rp, input logic [31:0] va, input logic [31:0] rflags,
                         input logic [31:0] pt, input logic [31:0] pflags, input logic [31:0] gt,
                         input logic [31:0] pdesc, input bit big);
        logic [31:0] ra, pa, ga;
        ra = (rp & ~32'h1FF) + ((va >> 25) & 32'h7F) * 4;
        pa = pt + ((va >> 18) & 32'h7F) * 4;
        ga = big ? gt + ((va >> 13) & 32'h1F) * 4 : gt + ((va >> 12) & 32'h3F) * 4;
        mem[ra] = pt | rflags;
        mem[pa] = gt | pflags;
        mem[ga] = pdesc;
    endtask

    task automatic run(input string tag, input logic [31:0] va, input logic [2:0] fc,
                       input bit wr, input bit tst, input bit big);
        @(negedge clk);
        req_addr = va; req_fc = fc; req_write = wr; req_test = tst; req_big_page = big;
        req_valid = 1'b1;
        predict(va, fc, wr, tst, big);
        cur_tag = tag;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        pending = 1'b1;
        for (int k = 0; k < 400 && pending; k++) @(negedge clk);
        if (pending) begin
            chk(1'b0, {tag, " no done"}, 32'h0, 32'h1);
            pending = 1'b0;
        end
    endtask

    // Memory responder and per-clock comparison against the model.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else begin
            if (mem_req) begin
                if (exp_q.size() == 0) chk(1'b0, {cur_tag, " unexpected read"}, mem_addr, 32'h0);
                else chk(mem_addr == exp_q[0], {cur_tag, " mem_addr"}, mem_addr, exp_q[0]);
                if (wait_cnt >= lat) begin
                    mem_ack = 1'b1;
                    mem_rdata = rd(mem_addr);
                    wait_cnt = 0;
                    if (exp_q.size() != 0) void'(exp_q.pop_front());
                end else begin
                    mem_ack = 1'b0;
                    wait_cnt++;
                end
            end else begin
                mem_ack = 1'b0;
                wait_cnt = 0;
            end
            if (done) begin
                if (pending) begin
                    chk(phys_addr == exp_pa, {cur_tag, " phys_addr"}, phys_addr, exp_pa);
                    chk(bus_err == exp_err, {cur_tag, " bus_err"}, {31'b0, bus_err}, {31'b0, exp_err});
                    chk(exp_q.size() == 0, {cur_tag, " reads left"}, exp_q.size(), 32'h0);
                    pending = 1'b0;
                end else begin
                    chk(1'b0, "R12 unexpected done", 32'h1, 32'h0);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R12 watchdog actual=%0d expected=%0d", n_chk, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R12 reset ready", {31'b0, req_ready}, 32'h1);
        chk(mem_req == 1'b0, "R12 reset mem_req", {31'b0, mem_req}, 32'h0);
        chk(done == 1'b0, "R12 reset done", {31'b0, done}, 32'h0);
        chk(bus_err == 1'b0, "R12 reset bus_err", {31'b0, bus_err}, 32'h0);

        // 4 KB walks through user and supervisor roots
        lat = 0;
        build(root_user, 32'h1234_5678, 32'h2, 32'h0010_0000, 32'h2, 32'h0010_0800, 32'hABCD_E001, 1'b0);
        run("R5 small page user", 32'h1234_5678, 3'd1, 1'b0, 1'b0, 1'b0);
        build(root_super, 32'h1234_5678, 32'h2, 32'h0011_0000, 32'h2, 32'h0011_0800, 32'h5555_5003, 1'b0);
        lat = 2;
        run("R3 supervisor root", 32'h1234_5678, 3'd5, 1'b0, 1'b0, 1'b0);
        run("R4 pointer level user again", 32'h1234_5678, 3'd2, 1'b0, 1'b0, 1'b0);

        // 8 KB walk
        lat = 1;
        build(root_user, 32'h2468_ACE0, 32'h2, 32'h0012_0000, 32'h2, 32'h0012_0C80, 32'h7777_6001, 1'b1);
        run("R6 big page", 32'h2468_ACE0, 3'd1, 1'b0, 1'b0, 1'b1);

        // Indirection
        lat = 0;
        build(root_user, 32'h3000_5000, 32'h2, 32'h0013_0000, 32'h2, 32'h0013_0800, 32'h0014_0002, 1'b0);
        mem[32'h0014_0000] = 32'h9999_9001;
        run("R7 indirect", 32'h3000_5000, 3'd1, 1'b0, 1'b0, 1'b0);
        build(root_user, 32'h3100_6000, 32'h2, 32'h0015_0000, 32'h2, 32'h0015_0800, 32'h0014_0102, 1'b0);
        mem[32'h0014_0100] = 32'h0014_0202;
        run("R8 double indirect", 32'h3100_6000, 3'd1, 1'b0, 1'b0, 1'b0);
        run("R8 double indirect test", 32'h3100_6000, 3'd1, 1'b0, 1'b1, 1'b0);
        mem[32'h0014_0100] = 32'h0;
        run("R9 indirect to invalid", 32'h3100_6000, 3'd1, 1'b0, 1'b0, 1'b0);

        // Invalid page descriptor
        build(root_user, 32'h3200_7000, 32'h2, 32'h0016_0000, 32'h2, 32'h0016_0800, 32'h0, 1'b0);
        run("R9 invalid page", 32'h3200_7000, 3'd1, 1'b0, 1'b0, 1'b0);
        run("R11 invalid page test", 32'h3200_7000, 3'd1, 1'b0, 1'b1, 1'b0);

        // Write protection on root and pointer levels
        lat = 1;
        build(root_user, 32'h3400_8000, 32'h6, 32'h0017_0000, 32'h2, 32'h0017_0800, 32'h1111_1001, 1'b0);
        run("R10 root wp write", 32'h3400_8000, 3'd1, 1'b1, 1'b0, 1'b0);
        run("R10 root wp read", 32'h3400_8000, 3'd1, 1'b0, 1'b0, 1'b0);
        run("R11 root wp write test", 32'h3400_8000, 3'd1, 1'b1, 1'b1, 1'b0);
        build(root_user, 32'h3600_9000, 32'h2, 32'h0018_0000, 32'h6, 32'h0018_0800, 32'h2222_2001, 1'b0);
        run("R10 ptr wp write", 32'h3600_9000, 3'd1, 1'b1, 1'b0, 1'b0);

        // Invalid pointer and root entries
        lat = 0;
        build(root_user, 32'h3800_A000, 32'h2, 32'h0019_0000, 32'h0, 32'h0019_0800, 32'h3333_3001, 1'b0);
        run("R4 invalid pointer", 32'h3800_A000, 3'd1, 1'b0, 1'b0, 1'b0);
        run("R11 invalid pointer test", 32'h3800_A000, 3'd1, 1'b0, 1'b1, 1'b0);
        run("R3 invalid root", 32'h7E00_0000, 3'd1, 1'b0, 1'b0, 1'b0);
        run("R11 invalid root test", 32'h7E00_0000, 3'd1, 1'b0, 1'b1, 1'b0);

        // Transparent windows
        tt_win0 = 32'h4000_8000;
        tt_win1 = 32'h800F_C004;
        run("R1 window0 user hit", 32'h4000_1234, 3'd1, 1'b0, 1'b0, 1'b0);
        run("R1 window0 supervisor miss", 32'h4000_1234, 3'd5, 1'b0, 1'b0, 1'b0);
        run("R1 window1 masked hit", 32'h8A00_0010, 3'd5, 1'b0, 1'b0, 1'b0);
        run("R2 window1 write", 32'h8A00_0010, 3'd5, 1'b1, 1'b0, 1'b0);
        run("R11 window1 write test", 32'h8A00_0010, 3'd1, 1'b1, 1'b1, 1'b0);
        run("R1 window1 address miss", 32'h9000_0000, 3'd1, 1'b0, 1'b0, 1'b0);
        run("R2 window0 write no wp", 32'h4000_1234, 3'd1, 1'b1, 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R12 idle after walks", {31'b0, req_ready}, 32'h1);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule